// File: doc/BRIEF.md
# Scatter-Gather Transmit DMA Engine

This engine follows a chain of descriptors in memory and sends the bytes of each descriptor's buffer out on a byte stream that carries frame markers. Software fills in the descriptors, loads the current-descriptor pointer and the control register, and then writes the tail pointer. That write starts the walk. The engine works through the chain on its own. It fetches each descriptor, streams its buffer, and writes a completion flag back into the descriptor. It stops after it has handled the descriptor whose address equals the tail pointer.

A frame may be spread over several descriptors. The first byte of a descriptor flagged as a frame start opens a frame. The last byte of a descriptor flagged as a frame end closes it. Completed frame-end descriptors are counted. An interrupt is raised once a programmable number of them have finished.

A descriptor is eight 32-bit words at consecutive byte addresses D, D+4, and so on up to D+28. The words are, in order:

| Word | Contents |
|------|----------|
| 0 | Next-descriptor pointer |
| 1 | Buffer byte address (any alignment) |
| 2 | Byte count |
| 3 | Flags |
| 4 to 7 | Application words, never touched by the engine |

The flags word uses three bits:

| Bit | Meaning |
|-----|---------|
| 27 | Frame start |
| 28 | Frame end |
| 31 | Done |

Top module: `sg_tx_dma`

Register map (`reg_addr`):

| Address | Name | Contents |
|---------|------|----------|
| 0 | Current pointer | Current-descriptor pointer |
| 1 | Tail pointer | Stop point; writing it starts the walk |
| 2 | Control | Bit 0 is interrupt enable; bits 15:8 are the coalescing threshold |
| 3 | Status | Bit 0 is busy, bit 1 is error, bit 2 is interrupt |

In the status register, writing 1 to bit 2 acknowledges the interrupt and writing 1 to bit 1 clears the error.

The memory port carries one access at a time. `mem_req` is held until `mem_ack`. Read data is taken from `mem_rdata` in the cycle in which `mem_ack` is high.

## Requirements
- R1: After reset the status register reads 0, `tx_valid`, `mem_req` and `irq` are low, and the current pointer reads 0.
- R2: A tail-pointer write while the engine is idle and the error bit is clear starts the walk. The first descriptor read is the one at the current-pointer address, and its words 0 to 3 are read at byte offsets 0, 4, 8 and 12.
- R3: No byte of a descriptor is output until all four of its descriptor words and its first buffer word have been read. For the first descriptor that is exactly 5 reads before the first byte.
- R4: Byte i of a descriptor is memory byte (buffer address + i), taken little-endian from its word, for exactly byte-count bytes.
- R5: `tx_sof` marks the first byte of a descriptor with bit 27 set, and `tx_eof` marks the last byte of a descriptor with bit 28 set. A frame without bit 28 continues into the next descriptor.
- R6: When a descriptor finishes, word 3 is written back with bit 31 set and its other bits unchanged. Words 4 to 7 are left unchanged.
- R7: After finishing a descriptor whose address is not the tail pointer, the current pointer takes word 0 and the next fetch starts. At the tail the engine stops with busy low and the current pointer equal to the tail.
- R8: A tail-pointer write while busy moves only the stop point. It does not restart the walk, and the current pointer is changed only by the engine.
- R9: The interrupt is high when bit 0 of control is set and the number of finished frame-end descriptors is at least the threshold (a threshold of 0 counts as 1). It stays high until acknowledged, and the acknowledge clears the count.
- R10: A descriptor with byte count 0 sets the error bit and makes the engine idle, with no byte output and no write-back for it. While the error bit is set a tail write starts nothing, and writing 1 to status bit 1 clears it.
- R11: A descriptor without bit 27 met while no frame is open sets the error bit and makes the engine idle, with no byte output for it.
- R12: While `tx_valid` is high and `tx_ready` low, the data and markers hold and `tx_valid` stays high.
- R13: While `mem_req` is high without `mem_ack`, the request, its address and its direction hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |
| tx_ready | input | 1 | Stream sink accepts the byte |
| irq | output | 1 | Coalesced interrupt |

## Verification
The bench uses a frame spread over three descriptors, one of them with an unaligned buffer. A design that restarts markers at each descriptor would show a stray start or end marker inside the frame, and one that ignores the low address bits would send shifted bytes. It also extends the tail pointer in the middle of a walk. A design that restarts on that write would fetch the first descriptor twice, and one that latches the tail at start would stop early. Zero-length descriptors and a missing frame start are used to check that the engine halts without sending bytes or writing back, and that it cannot be restarted until the error is cleared. The threshold is set just at and just above the number of frame ends, so an off-by-one comparison shows up as a wrong interrupt level.

// File: rtl/sg_tx_pkg.sv
package sg_tx_pkg;
    localparam int unsigned DW         = 32;
    localparam int unsigned FETCH_WDS  = 4;
    localparam int unsigned FLAG_SOF   = 27;
    localparam int unsigned FLAG_EOF   = 28;
    localparam int unsigned FLAG_DONE  = 31;

    localparam logic [1:0] RA_CUR    = 2'd0;
    localparam logic [1:0] RA_TAIL   = 2'd1;
    localparam logic [1:0] RA_CTRL   = 2'd2;
    localparam logic [1:0] RA_STATUS = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_RDATA,
        ST_EMIT,
        ST_WBACK
    } eng_state_e;

    typedef struct packed {
        logic [DW-1:0] nxt;
        logic [DW-1:0] buf_addr;
        logic [DW-1:0] len;
        logic [DW-1:0] flags;
    } desc_t;

    function automatic logic [DW-1:0] mark_done(input logic [DW-1:0] f);
        return f | (DW'(1) << FLAG_DONE);
    endfunction
endpackage

// File: rtl/sg_tx_regs.sv
module sg_tx_regs
    import sg_tx_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned CNT_W = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          busy,
    input  logic          adv,
    input  logic [AW-1:0] adv_ptr,
    input  logic          err_set,
    input  logic          eop_done,
    output logic          start,
    output logic [AW-1:0] cur_ptr,
    output logic [AW-1:0] tail_ptr,
    output logic          irq
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [AW-1:0]    cur_q, tail_q;
    logic             irq_en, err_q;
    logic [CNT_W-1:0] thr_q, cnt_q, cnt_base, thr_eff;
    logic             wr_cur, wr_tail, wr_ctrl, wr_stat, ack_irq, clr_err;

    assign wr_cur  = reg_we && reg_addr == RA_CUR;
    assign wr_tail = reg_we && reg_addr == RA_TAIL;
    assign wr_ctrl = reg_we && reg_addr == RA_CTRL;
    assign wr_stat = reg_we && reg_addr == RA_STATUS;
    assign ack_irq = wr_stat && reg_wdata[2];
    assign clr_err = wr_stat && reg_wdata[1];
    assign start   = wr_tail && !busy && !err_q;

    assign cnt_base = ack_irq ? '0 : cnt_q;
    assign thr_eff  = (thr_q == '0) ? CNT_W'(1) : thr_q;
    assign irq      = irq_en && (cnt_q >= thr_eff);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            tail_q <= '0;
            irq_en <= 1'b0;
            thr_q  <= '0;
            cnt_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            if (adv)
                cur_q <= adv_ptr;
            else if (wr_cur && !busy)
                cur_q <= reg_wdata[AW-1:0];
            if (wr_tail)
                tail_q <= reg_wdata[AW-1:0];
            if (wr_ctrl) begin
                irq_en <= reg_wdata[0];
                thr_q  <= reg_wdata[8 +: CNT_W];
            end
            if (eop_done && cnt_base != CNT_MAX)
                cnt_q <= cnt_base + CNT_W'(1);
            else
                cnt_q <= cnt_base;
            if (err_set)
                err_q <= 1'b1;
            else if (clr_err)
                err_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (reg_addr)
            RA_CUR:  reg_rdata = DW'(cur_q);
            RA_TAIL: reg_rdata = DW'(tail_q);
            RA_CTRL: reg_rdata = DW'({thr_q, 7'd0, irq_en});
            default: reg_rdata = {{(DW-3){1'b0}}, irq, err_q, busy};
        endcase
    end

    assign cur_ptr  = cur_q;
    assign tail_ptr = tail_q;

    // R8: software cannot move the current pointer during a walk
    a_r8_cur_engine_only: assert property (@(posedge clk) disable iff (rst)
        busy && !adv |=> $stable(cur_q));

    // R9: interrupt holds until acknowledged (register writes excluded)
    a_r9_irq_holds: assert property (@(posedge clk) disable iff (rst)
        irq && !reg_we |=> irq);

    // R10: no start while the error bit is set
    a_r10_err_blocks: assert property (@(posedge clk) disable iff (rst)
        err_q && !clr_err && !busy |=> !busy);
endmodule

// File: rtl/sg_tx_engine.sv
module sg_tx_engine
    import sg_tx_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] cur_ptr,
    input  logic [AW-1:0] tail_ptr,
    output logic          adv,
    output logic [AW-1:0] adv_ptr,
    output logic          busy,
    output logic          err_set,
    output logic          eop_done,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    output logic [7:0]    tx_data,
    output logic          tx_valid,
    output logic          tx_sof,
    output logic          tx_eof,
    input  logic          tx_ready
);
    localparam int unsigned WI_W = $clog2(FETCH_WDS);

    eng_state_e      st;
    desc_t           d;
    logic [WI_W-1:0] widx;
    logic [AW-1:2]   rd_word;
    logic [1:0]      lane;
    logic [DW-1:0]   word, rem;
    logic            first, open;
    logic            f_sof, f_eof, bad, beat;

    assign f_sof = d.flags[FLAG_SOF];
    assign f_eof = d.flags[FLAG_EOF];
    assign bad   = (d.len == '0) || (!f_sof && !open);

    assign busy     = st != ST_IDLE;
    assign mem_req  = st == ST_FETCH || st == ST_RDATA || st == ST_WBACK;
    assign mem_we   = st == ST_WBACK;
    assign mem_wdata = mark_done(d.flags);
    assign tx_valid = st == ST_EMIT;
    assign tx_data  = word[8*lane +: 8];
    assign tx_sof   = tx_valid && first && f_sof;
    assign tx_eof   = tx_valid && f_eof && rem == DW'(1);
    assign beat     = tx_valid && tx_ready;
    assign err_set  = st == ST_CHECK && bad;
    assign eop_done = st == ST_WBACK && mem_ack && f_eof;
    assign adv      = st == ST_WBACK && mem_ack && cur_ptr != tail_ptr;
    assign adv_ptr  = d.nxt[AW-1:0];

    always_comb begin
        unique case (st)
            ST_FETCH: mem_addr = cur_ptr + {{(AW-WI_W-2){1'b0}}, widx, 2'b00};
            ST_RDATA: mem_addr = {rd_word, 2'b00};
            ST_WBACK: mem_addr = cur_ptr + AW'(12);
            default:  mem_addr = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            d       <= '0;
            widx    <= '0;
            rd_word <= '0;
            lane    <= '0;
            word    <= '0;
            rem     <= '0;
            first   <= 1'b0;
            open    <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: if (start) begin
                    st   <= ST_FETCH;
                    widx <= '0;
                end
                ST_FETCH: if (mem_ack) begin
                    unique case (widx)
                        2'd0:    d.nxt      <= mem_rdata;
                        2'd1:    d.buf_addr <= mem_rdata;
                        2'd2:    d.len      <= mem_rdata;
                        default: d.flags    <= mem_rdata;
                    endcase
                    widx <= widx + 1'b1;
                    if (widx == WI_W'(FETCH_WDS - 1))
                        st <= ST_CHECK;
                end
                ST_CHECK: begin
                    if (bad) begin
                        st   <= ST_IDLE;
                        open <= 1'b0;
                    end else begin
                        st      <= ST_RDATA;
                        rd_word <= d.buf_addr[AW-1:2];
                        lane    <= d.buf_addr[1:0];
                        rem     <= d.len;
                        first   <= 1'b1;
                        if (f_sof) open <= 1'b1;
                    end
                end
                ST_RDATA: if (mem_ack) begin
                    word    <= mem_rdata;
                    rd_word <= rd_word + 1'b1;
                    st      <= ST_EMIT;
                end
                ST_EMIT: if (beat) begin
                    first <= 1'b0;
                    rem   <= rem - DW'(1);
                    lane  <= lane + 2'd1;
                    if (tx_eof) open <= 1'b0;
                    if (rem == DW'(1))
                        st <= ST_WBACK;
                    else if (lane == 2'd3)
                        st <= ST_RDATA;
                end
                ST_WBACK: if (mem_ack) begin
                    widx <= '0;
                    st   <= (cur_ptr == tail_ptr) ? ST_IDLE : ST_FETCH;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R13: an access holds until acknowledged
    a_r13_req_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R12: stream byte holds under backpressure
    a_r12_tx_hold: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sof) && $stable(tx_eof));

    // R10, R11: a rejected descriptor idles the engine with no traffic
    a_r10_err_halts: assert property (@(posedge clk) disable iff (rst)
        err_set |=> !busy && !mem_req && !tx_valid);

    // R5: a start marker only on a descriptor's first byte
    a_r5_sof_first: assert property (@(posedge clk) disable iff (rst)
        beat |=> !tx_sof);
endmodule

// File: rtl/sg_tx_dma.sv
module sg_tx_dma
    import sg_tx_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned CNT_W = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic [7:0]    tx_data,
    output logic          tx_valid,
    output logic          tx_sof,
    output logic          tx_eof,
    input  logic          tx_ready,
    output logic          irq
);
    logic          start, adv, busy, err_set, eop_done;
    logic [AW-1:0] cur_ptr, tail_ptr, adv_ptr;

    sg_tx_regs #(.AW(AW), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .adv(adv), .adv_ptr(adv_ptr), .err_set(err_set), .eop_done(eop_done),
        .start(start), .cur_ptr(cur_ptr), .tail_ptr(tail_ptr), .irq(irq)
    );

    sg_tx_engine #(.AW(AW)) u_eng (
        .clk(clk), .rst(rst),
        .start(start), .cur_ptr(cur_ptr), .tail_ptr(tail_ptr),
        .adv(adv), .adv_ptr(adv_ptr), .busy(busy), .err_set(err_set), .eop_done(eop_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_sof(tx_sof), .tx_eof(tx_eof),
        .tx_ready(tx_ready)
    );
endmodule

// File: tb/sg_tx_dma_tb.sv
module sg_tx_dma_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic [7:0]  tx_data;
    logic        tx_valid, tx_sof, tx_eof, tx_ready = 1'b0, irq;

    always #2.5 clk = ~clk;

    sg_tx_dma u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_sof(tx_sof), .tx_eof(tx_eof),
        .tx_ready(tx_ready), .irq(irq)
    );

    int n_checks = 0, n_err = 0, cyc = 0;
    logic [31:0] mem [0:1023];
    logic [9:0]  exp_q [$];
    logic [31:0] done_q [$];
    logic [31:0] exp_last;
    bit          exp_err;
    int          exp_eops, nreads, reads_at_first;
    bit          seen_first;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // memory and sink model, driven away from the active edge
    always @(negedge clk) begin
        bit ak, rd;
        logic [9:0] e;
        if (rst) begin
            mem_ack  = 1'b0;
            tx_ready = 1'b0;
        end else begin
            ak = mem_req && ($urandom % 4 != 0);
            mem_ack = ak;
            if (ak) begin
                if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
                else begin
                    mem_rdata = mem[mem_addr[11:2]];
                    nreads++;
                end
            end
            rd = ($urandom % 3 != 0);
            tx_ready = rd;
            if (tx_valid && rd) begin
                if (!seen_first) begin
                    seen_first = 1;
                    reads_at_first = nreads;
                end
                if (exp_q.size() == 0)
                    check(0, "R4 unexpected byte", {22'd0, tx_eof, tx_sof, tx_data}, 0);
                else begin
                    e = exp_q.pop_front();
                    // R4 R5 R12: byte and markers at each handshake
                    check({tx_eof, tx_sof, tx_data} == e, "R4 R5 R12 stream beat",
                          {22'd0, tx_eof, tx_sof, tx_data}, {22'd0, e});
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_err++;
            $display("FAIL R7 watchdog expired actual=%0d expected<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic mk(input int a, input int nx, input int bp, input int ln, input logic [31:0] fl);
        mem[a/4]   = nx;
        mem[a/4+1] = bp;
        mem[a/4+2] = ln;
        mem[a/4+3] = fl | 32'h0000_0055;
        for (int k = 4; k < 8; k++) mem[a/4+k] = 32'hA000_0000 | (a + k);
    endtask

    task automatic fill_bufs();
        for (int w = 256; w < 320; w++)
            for (int b = 0; b < 4; b++) mem[w][8*b +: 8] = 8'((w*4 + b) * 7 + 3);
    endtask

    task automatic build_expect(input logic [31:0] cur, input logic [31:0] tail);
        logic [31:0] a, bp, ln, ct, ba;
        bit open;
        exp_q.delete(); done_q.delete();
        exp_err = 0; exp_eops = 0; open = 0; a = cur;
        for (int g = 0; g < 16; g++) begin
            bp = mem[a[11:2]+1]; ln = mem[a[11:2]+2]; ct = mem[a[11:2]+3];
            exp_last = a;
            if (ln == 0 || (!ct[27] && !open)) begin exp_err = 1; break; end
            if (ct[27]) open = 1;
            for (int i = 0; i < ln; i++) begin
                ba = bp + i;
                exp_q.push_back({ct[28] && i == ln - 1, ct[27] && i == 0, mem[ba[11:2]][8*ba[1:0] +: 8]});
            end
            if (ct[28]) begin open = 0; exp_eops++; end
            done_q.push_back(a);
            if (a == tail) break;
            a = mem[a[11:2]];
        end
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        repeat (3) @(negedge clk);
        for (int t = 0; t < 4000; t++) begin
            reg_rd(3, s);
            if (!s[0]) break;
        end
    endtask

    task automatic run_chain(input int cur, input int tail, input int ext, input logic [31:0] ctrl,
                             input bit exp_irq, input int bad_at);
        logic [31:0] v;
        build_expect(cur, (ext >= 0) ? ext : tail);
        seen_first = 0; nreads = 0;
        reg_wr(2, ctrl);
        reg_wr(0, cur);
        reg_wr(1, tail);
        if (ext >= 0) reg_wr(1, ext);   // R8: extend stop point mid-walk
        wait_idle();
        reg_rd(3, v);
        check(v[0] == 0, "R7 busy low at end", v, 0);
        check(v[1] == exp_err, "R10 R11 error bit", v[1], exp_err);
        check(v[2] == exp_irq && irq == exp_irq, "R9 interrupt level", irq, exp_irq);
        reg_rd(0, v);
        check(v == exp_last, "R7 R8 final current pointer", v, exp_last);
        check(exp_q.size() == 0, "R5 all bytes sent", exp_q.size(), 0);
        if (seen_first)
            check(reads_at_first == 5, "R2 R3 reads before first byte", reads_at_first, 5);
        foreach (done_q[i]) begin
            check(mem[done_q[i]/4+3] == (32'h8000_0055 | (mem[done_q[i]/4+3] & 32'h1800_0000)),
                  "R6 R13 write-back flags", mem[done_q[i]/4+3], 32'h8000_0055);
            check(mem[done_q[i]/4+5] == (32'hA000_0000 | (done_q[i] + 5)), "R6 app word kept",
                  mem[done_q[i]/4+5], 32'hA000_0000 | (done_q[i] + 5));
        end
        if (bad_at >= 0)
            check(mem[bad_at/4+3][31] == 0, "R10 R11 no write-back on rejected descriptor",
                  mem[bad_at/4+3], 0);
    endtask

    task automatic build_frames();
        fill_bufs();
        mk(32'h100, 32'h120, 32'h400, 5, 32'h0800_0000);
        mk(32'h120, 32'h140, 32'h408, 3, 32'h0000_0000);
        mk(32'h140, 32'h160, 32'h411, 6, 32'h1000_0000);
        mk(32'h160, 32'h100, 32'h420, 4, 32'h1800_0000);
    endtask

    initial begin
        logic [31:0] v;
        do_reset();
        // R1: reset state
        reg_rd(3, v);
        check(v == 0, "R1 status after reset", v, 0);
        reg_rd(0, v);
        check(v == 0, "R1 current pointer after reset", v, 0);
        check(!tx_valid && !mem_req && !irq, "R1 outputs idle", {tx_valid, mem_req, irq}, 0);

        // multi-descriptor frame, unaligned buffer, threshold met (R2 R4 R5 R6 R7 R9)
        build_frames();
        run_chain(32'h100, 32'h160, -1, 32'h0000_0201, 1'b1, -1);
        reg_wr(3, 32'h4);
        @(negedge clk);
        check(irq == 0, "R9 acknowledge clears interrupt", irq, 0);

        // threshold one above the number of frame ends (R9)
        do_reset();
        build_frames();
        run_chain(32'h100, 32'h160, -1, 32'h0000_0301, 1'b0, -1);

        // tail extended while busy, interrupt disabled (R8 R9)
        do_reset();
        mk(32'h200, 32'h220, 32'h430, 2, 32'h1800_0000);
        mk(32'h220, 32'h240, 32'h434, 3, 32'h1800_0000);
        mk(32'h240, 32'h200, 32'h43A, 1, 32'h1800_0000);
        run_chain(32'h200, 32'h200, 32'h240, 32'h0, 1'b0, -1);

        // zero-length descriptor (R10)
        do_reset();
        mk(32'h100, 32'h120, 32'h400, 0, 32'h1800_0000);
        run_chain(32'h100, 32'h100, -1, 32'h0, 1'b0, 32'h100);
        seen_first = 0;
        reg_wr(1, 32'h100);
        repeat (20) @(negedge clk);
        reg_rd(3, v);
        check(v[0] == 0 && !seen_first, "R10 tail write ignored while error set", v, 32'h2);
        reg_wr(3, 32'h2);
        reg_rd(3, v);
        check(v[1] == 0, "R10 error clear", v, 0);

        // frame continuation without an open frame (R11)
        do_reset();
        mk(32'h100, 32'h120, 32'h400, 3, 32'h1000_0000);
        run_chain(32'h100, 32'h100, -1, 32'h0, 1'b0, 32'h100);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule